// File: doc/BRIEF.md
# Predictive Voltage/Frequency Level Selector

Once per accelerator job, this block turns a small vector of control-path counts into a choice of operating point. These counts are things such as how often a control state machine took a given transition, or the final value of a loop counter. Each count is multiplied by a programmable fixed-point weight. The weighted counts are summed with saturation into an estimate of the job's cycle count. The block then searches a table of per-level clock frequencies for the slowest level at which the estimate, inflated by a safety margin, still fits in the per-job time budget. The budget is the frame deadline. If the candidate level differs from the level currently in use, the time needed to switch levels is taken out of that budget.

A job enters through a valid/ready handshake. The features, weights, current level and frequency table are all captured at acceptance. The level decision leaves through a second valid/ready handshake. The result stays on the output until the consumer takes it. A new job is accepted only after that. If no level can meet the budget, the block picks the fastest level and raises a risk flag.

Top module: `dvfs_level_pick`

## Requirements
- R1: After reset, `res_valid` is low and `job_ready` is high.
- R2: A job is accepted only on a clock edge where `job_valid` and `job_ready` are both high. `job_ready` stays low from acceptance until the result is taken. Input values presented while the block is busy have no effect on the result.
- R3: `res_valid` rises exactly NFEAT+1 clock edges after the accepting edge (8 with defaults).
- R4: While `res_valid` is high and `res_ready` is low, `res_valid`, `res_level` and `res_deadline_risk` hold their values. The result is consumed on an edge where both are high.
- R5: The accumulator is the sum over all features of feature × weight (unsigned). The predicted cycle count is the accumulator shifted right by CFRAC bits (weights carry 4 fractional bits by default). Level i fits when pred × (100 + MARGIN_PCT) ≤ budget_i × freq_i × 100, where freq_i is in MHz and the budget is in µs.
- R6: budget_i equals DEADLINE_US (16700) when i equals the captured current level. Otherwise it equals DEADLINE_US − SWITCH_US (16600).
- R7: `res_level` is the lowest index i that fits. Level 0 is the lowest-voltage point and index NLVL−1 is the highest. When at least one level fits, `res_deadline_risk` is 0.
- R8: When no level fits, `res_level` is NLVL−1 (5) and `res_deadline_risk` is 1.
- R9: The accumulation saturates at 2^AW − 1 and never wraps, whatever the order of the products.
- R10: `res_level` is always below NLVL while `res_valid` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| job_valid | input | 1 | A job's inputs are presented |
| job_ready | output | 1 | The block can accept a job (idle) |
| job_feat | input | NFEAT*FW | Feature counts; feature k in bits [k*FW +: FW] |
| job_coef | input | NFEAT*CW | Weights with CFRAC fractional bits; weight k in bits [k*CW +: CW] |
| job_cur_level | input | LW | Level in use when the job arrives |
| lvl_freq | input | NLVL*FRW | Frequency in MHz of level i in bits [i*FRW +: FRW], ascending with i |
| res_valid | output | 1 | A level decision is available |
| res_ready | input | 1 | The consumer takes the decision |
| res_level | output | LW | Chosen level index |
| res_deadline_risk | output | 1 | No level met the budget |

## Verification
The assertions assume a few things about the inputs. The frequency table is ordered ascending with level index. `job_cur_level` names an existing level. `res_ready` is driven only with legal values, and the consumer may stall for any number of cycles. The stimulus always writes the table in ascending order and draws the current level from 0 to NLVL−1. It holds `res_ready` low for random stretches and drives `job_valid` with scrambled data while the block is busy, so the handshake rules are tested under stalls. Features and weights are drawn so that the estimates fall on both sides of the level thresholds. Directed jobs sit exactly at the switching-overhead boundary and just past the point where an unsaturated sum would wrap.

// File: rtl/dvfs_sel_pkg.sv
package dvfs_sel_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_MAC  = 2'd1,
    ST_EVAL = 2'd2,
    ST_HOLD = 2'd3
  } sel_state_t;

  localparam int unsigned PCT_SCALE = 100;
endpackage

// File: rtl/dvfs_mac_sat.sv
module dvfs_mac_sat #(
  parameter int FW = 16,
  parameter int CW = 16,
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic          en,
  input  logic [FW-1:0] feat,
  input  logic [CW-1:0] coef,
  output logic [AW-1:0] acc
);
  localparam int PW = FW + CW;
  localparam int SW = ((PW > AW) ? PW : AW) + 1;
  localparam logic [SW-1:0] ACC_MAX = (SW'(1) << AW) - SW'(1);

  logic [SW-1:0] prod_w;
  logic [SW-1:0] sum_w;
  logic [AW-1:0] next_acc;

  always_comb begin
    prod_w   = SW'(feat) * SW'(coef);
    sum_w    = SW'(acc) + prod_w;
    next_acc = (sum_w > ACC_MAX) ? ACC_MAX[AW-1:0] : sum_w[AW-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     acc <= '0;
    else if (clear) acc <= '0;
    else if (en)    acc <= next_acc;
  end
endmodule

// File: rtl/dvfs_level_scan.sv
module dvfs_level_scan #(
  parameter int NLVL        = 6,
  parameter int FRW         = 10,
  parameter int AW          = 32,
  parameter int CFRAC       = 4,
  parameter int MARGIN_PCT  = 5,
  parameter int DEADLINE_US = 16700,
  parameter int SWITCH_US   = 100,
  parameter int LW          = 3
) (
  input  logic [AW-1:0]       acc,
  input  logic [NLVL*FRW-1:0] freq_flat,
  input  logic [LW-1:0]       cur_level,
  output logic [LW-1:0]       pick,
  output logic                none_fit
);
  import dvfs_sel_pkg::*;
  localparam int CMW = 64;
  localparam logic [CMW-1:0] LHS_SCALE  = CMW'(PCT_SCALE + MARGIN_PCT);
  localparam logic [CMW-1:0] FULL_BUDG  = CMW'(DEADLINE_US);
  localparam logic [CMW-1:0] SHORT_BUDG = CMW'(DEADLINE_US - SWITCH_US);

  logic [CMW-1:0]  pred_w;
  logic [CMW-1:0]  need_w;
  logic [NLVL-1:0] fit;

  assign pred_w = CMW'(acc >> CFRAC);
  assign need_w = pred_w * LHS_SCALE;

  for (genvar i = 0; i < NLVL; i++) begin : g_lvl
    logic [CMW-1:0] budget_w;
    logic [CMW-1:0] avail_w;
    assign budget_w = (cur_level == LW'(i)) ? FULL_BUDG : SHORT_BUDG;
    assign avail_w  = budget_w * CMW'(freq_flat[i*FRW +: FRW]) * CMW'(PCT_SCALE);
    assign fit[i]   = (need_w <= avail_w);
  end

  always_comb begin
    pick     = LW'(NLVL - 1);
    none_fit = 1'b1;
    for (int i = NLVL - 1; i >= 0; i--) begin
      if (fit[i]) begin
        pick     = LW'(i);
        none_fit = 1'b0;
      end
    end
  end
endmodule

// File: rtl/dvfs_level_pick.sv
module dvfs_level_pick #(
  parameter int NFEAT       = 7,
  parameter int FW          = 16,
  parameter int CW          = 16,
  parameter int AW          = 32,
  parameter int CFRAC       = 4,
  parameter int NLVL        = 6,
  parameter int FRW         = 10,
  parameter int MARGIN_PCT  = 5,
  parameter int DEADLINE_US = 16700,
  parameter int SWITCH_US   = 100,
  localparam int LW = (NLVL > 1) ? $clog2(NLVL) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                job_valid,
  output logic                job_ready,
  input  logic [NFEAT*FW-1:0] job_feat,
  input  logic [NFEAT*CW-1:0] job_coef,
  input  logic [LW-1:0]       job_cur_level,
  input  logic [NLVL*FRW-1:0] lvl_freq,
  output logic                res_valid,
  input  logic                res_ready,
  output logic [LW-1:0]       res_level,
  output logic                res_deadline_risk
);
  import dvfs_sel_pkg::*;
  localparam int IW = (NFEAT > 1) ? $clog2(NFEAT) : 1;
  localparam logic [IW-1:0] LAST_IDX = IW'(NFEAT - 1);

  sel_state_t          state;
  logic [IW-1:0]       idx;
  logic [NFEAT*FW-1:0] feat_q;
  logic [NFEAT*CW-1:0] coef_q;
  logic [LW-1:0]       cur_q;
  logic [NLVL*FRW-1:0] freq_q;
  logic [AW-1:0]       acc;
  logic [LW-1:0]       pick;
  logic                none_fit;
  logic                accept;

  assign job_ready = (state == ST_IDLE);
  assign res_valid = (state == ST_HOLD);
  assign accept    = job_valid && job_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state             <= ST_IDLE;
      idx               <= '0;
      feat_q            <= '0;
      coef_q            <= '0;
      cur_q             <= '0;
      freq_q            <= '0;
      res_level         <= '0;
      res_deadline_risk <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE: if (accept) begin
          feat_q <= job_feat;
          coef_q <= job_coef;
          cur_q  <= job_cur_level;
          freq_q <= lvl_freq;
          idx    <= '0;
          state  <= ST_MAC;
        end
        ST_MAC: begin
          idx <= idx + IW'(1);
          if (idx == LAST_IDX) state <= ST_EVAL;
        end
        ST_EVAL: begin
          res_level         <= pick;
          res_deadline_risk <= none_fit;
          state             <= ST_HOLD;
        end
        ST_HOLD: if (res_ready) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  dvfs_mac_sat #(.FW(FW), .CW(CW), .AW(AW)) u_mac (
    .clk   (clk),
    .rst_n (rst_n),
    .clear (accept),
    .en    (state == ST_MAC),
    .feat  (feat_q[idx*FW +: FW]),
    .coef  (coef_q[idx*CW +: CW]),
    .acc   (acc)
  );

  dvfs_level_scan #(
    .NLVL(NLVL), .FRW(FRW), .AW(AW), .CFRAC(CFRAC), .MARGIN_PCT(MARGIN_PCT),
    .DEADLINE_US(DEADLINE_US), .SWITCH_US(SWITCH_US), .LW(LW)
  ) u_scan (
    .acc       (acc),
    .freq_flat (freq_q),
    .cur_level (cur_q),
    .pick      (pick),
    .none_fit  (none_fit)
  );
endmodule

// File: rtl/dvfs_level_pick_chk.sv
module dvfs_level_pick_chk #(
  parameter int NFEAT = 7,
  parameter int NLVL  = 6,
  parameter int LW    = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          job_valid,
  input logic          job_ready,
  input logic          res_valid,
  input logic          res_ready,
  input logic [LW-1:0] res_level,
  input logic          res_deadline_risk
);
  logic [7:0] lat;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      lat <= '0;
    else if (job_valid && job_ready) lat <= '0;
    else if (!res_valid && lat != 8'hFF) lat <= lat + 8'd1;
  end

  assert_reset_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (!res_valid && job_ready));

  assert_busy_not_ready_R2: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> !job_ready);

  assert_fixed_latency_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(res_valid) |-> (lat == 8'(NFEAT + 1)));

  assert_hold_stable_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_ready) |=> (res_valid && $stable(res_level) && $stable(res_deadline_risk)));

  assert_risk_top_level_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_deadline_risk) |-> (res_level == LW'(NLVL - 1)));

  assert_level_range_R10: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> (int'(res_level) < NLVL));
endmodule

bind dvfs_level_pick dvfs_level_pick_chk #(.NFEAT(NFEAT), .NLVL(NLVL), .LW(LW)) u_chk (
  .clk               (clk),
  .rst_n             (rst_n),
  .job_valid         (job_valid),
  .job_ready         (job_ready),
  .res_valid         (res_valid),
  .res_ready         (res_ready),
  .res_level         (res_level),
  .res_deadline_risk (res_deadline_risk)
);

// File: tb/dvfs_level_pick_test.sv
module dvfs_level_pick_test;
  localparam int NFEAT = 7, FW = 16, CW = 16, NLVL = 6, FRW = 10, LW = 3;
  localparam int FREQ [NLVL] = '{50, 80, 120, 160, 200, 250};

  logic clk = 1'b0, rst_n = 1'b0;
  logic job_valid = 1'b0, res_ready = 1'b0;
  logic job_ready, res_valid, res_deadline_risk;
  logic [NFEAT*FW-1:0] job_feat = '0;
  logic [NFEAT*CW-1:0] job_coef = '0;
  logic [LW-1:0] job_cur_level = '0, res_level;
  logic [NLVL*FRW-1:0] lvl_freq;

  int n_chk = 0, n_fail = 0;
  int unsigned fv [NFEAT];
  int unsigned cv [NFEAT];
  int unsigned seed = 32'h5eed_1234;

  always #5ns clk = ~clk;

  dvfs_level_pick uut (
    .clk(clk), .rst_n(rst_n), .job_valid(job_valid), .job_ready(job_ready),
    .job_feat(job_feat), .job_coef(job_coef), .job_cur_level(job_cur_level),
    .lvl_freq(lvl_freq), .res_valid(res_valid), .res_ready(res_ready),
    .res_level(res_level), .res_deadline_risk(res_deadline_risk)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int exp_level(input int cur, output bit risk);
    longint unsigned acc = 0, pred, bud;
    for (int k = 0; k < NFEAT; k++) begin
      acc += longint'(fv[k]) * longint'(cv[k]);
      if (acc > 64'hFFFF_FFFF) acc = 64'hFFFF_FFFF;
    end
    pred = acc >> 4;
    for (int i = 0; i < NLVL; i++) begin
      bud = (i == cur) ? 16700 : 16600;
      if (pred * 105 <= bud * FREQ[i] * 100) begin
        risk = 1'b0;
        return i;
      end
    end
    risk = 1'b1;
    return NLVL - 1;
  endfunction

  task automatic run_job(input int cur, input int hold, input string tag);
    bit erisk;
    int elvl, n;
    elvl = exp_level(cur, erisk);
    @(negedge clk);
    for (int k = 0; k < NFEAT; k++) begin
      job_feat[k*FW +: FW] = FW'(fv[k]);
      job_coef[k*CW +: CW] = CW'(cv[k]);
    end
    job_cur_level = LW'(cur);
    chk(job_ready == 1'b1, "R2 ready before job", job_ready, 1);
    job_valid = 1'b1;
    @(negedge clk);
    job_feat = {4{$urandom}};
    job_coef = {4{$urandom}};
    job_cur_level = LW'($urandom % NLVL);
    n = 0;
    do begin
      @(negedge clk);
      n++;
      if (n == 2) begin
        chk(job_ready == 1'b0, "R2 busy not ready", job_ready, 0);
        job_valid = 1'b0;
      end
    end while (!res_valid && n < 40);
    chk(n == NFEAT + 1, "R3 latency", n, NFEAT + 1);
    chk(int'(res_level) == elvl, {"R5 R6 R7 level ", tag}, res_level, elvl);
    chk(res_deadline_risk == erisk, {"R8 risk ", tag}, res_deadline_risk, erisk);
    for (int h = 0; h < hold; h++) begin
      @(negedge clk);
      chk(res_valid && int'(res_level) == elvl && res_deadline_risk == erisk,
          "R4 hold under stall", res_level, elvl);
    end
    res_ready = 1'b1;
    @(negedge clk);
    res_ready = 1'b0;
    chk(!res_valid && job_ready, "R4 consumed", res_valid, 0);
  endtask

  initial begin
    #(200000 * 10ns);
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(seed));
    for (int i = 0; i < NLVL; i++) lvl_freq[i*FRW +: FRW] = FRW'(FREQ[i]);
    #1ns;
    chk(res_valid == 1'b0, "R1 reset valid", res_valid, 0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(res_valid == 1'b0 && job_ready == 1'b1, "R1 idle after reset", job_ready, 1);

    // R7 all-zero job lands on level 0
    for (int k = 0; k < NFEAT; k++) begin fv[k] = 0; cv[k] = 0; end
    run_job(0, 2, "zero");
    // R6 boundary: pred 795238 fits level 0 only without switching cost
    fv[0] = 3106; cv[0] = 4096; fv[1] = 1632; cv[1] = 1;
    run_job(0, 0, "edge same level");
    run_job(2, 1, "edge switch");
    fv[1] = 1648;
    run_job(0, 0, "edge plus one");
    // R9 saturation: an unsaturated sum would wrap to 15
    for (int k = 0; k < NFEAT; k++) begin fv[k] = 0; cv[k] = 0; end
    fv[0] = 65535; cv[0] = 65535; fv[1] = 65535; cv[1] = 2; fv[2] = 16; cv[2] = 1;
    run_job(0, 0, "R9 saturate");
    chk(res_deadline_risk == 1'b1, "R9 saturated flag", res_deadline_risk, 1);
    for (int k = 0; k < NFEAT; k++) begin fv[k] = 65535; cv[k] = 65535; end
    run_job(5, 3, "R8 all max");

    for (int j = 0; j < 60; j++) begin
      for (int k = 0; k < NFEAT; k++) begin
        fv[k] = $urandom % 4096;
        cv[k] = (j % 3 == 0) ? ($urandom % 1024) : ($urandom % 4096);
      end
      run_job($urandom % NLVL, $urandom % 4, "random");
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule